// File: doc/BRIEF.md
# DMA Address Generator

The block produces the memory address sequence for one direct-memory-access transfer, and it decides when that transfer ends. A sequencer drives a 3-bit opcode together with a valid strobe. With these opcodes it writes a 3-bit mode register, loads the address and word counters, reads back any register on a data bus, reinitialises both counters from their stored start values, and arms counting. After the block is armed, every cycle in which the transfer engine raises `count_en_i` advances the address by one, up or down, and updates the word counter.

The mode register selects one of four end-of-transfer conditions: the word count running down to one, an up-counting word counter reaching the stored count, the address reaching a stored end address, or the word counter carrying out of its top bit. When the condition is met, the block raises a registered, sticky `done_o`. This flag freezes both counters until software loads a counter or reinitialises.

Top module: `dmag_addr_gen`

## Requirements
- R1: After reset `addr_o` is 0, `done_o` is 0, `data_o` is 0, the mode register is 0 and counting is disarmed.
- R2: Opcode 0 with `op_valid_i` stores `data_i[2:0]` as the mode register and ignores all higher bits. Opcode 1 places the mode register, zero-extended, on `data_o` one cycle later, and `data_o` then holds that value until the next read opcode.
- R3: Opcode 5 loads `data_i` into the address counter and its start register. Opcode 6 loads `data_i` into the stored word count. The word counter itself starts at `data_i` in modes 0 and 3 and at zero in modes 1 and 2. Opcode 3 reads the address counter and opcode 2 reads the word counter, each with one cycle of latency.
- R4: Opcode 7 arms counting. Opcodes 0, 4, 5 and 6 disarm it. The counters step only on a cycle in which counting is armed, `count_en_i` is 1 and `done_o` is 0.
- R5: Mode bit 2 picks the address direction: 0 steps the address by +1 and 1 steps it by -1, modulo 2^16.
- R6: Mode low bits 0 (count-to-one): the word counter steps down, and the step taken while it holds 1 sets `done_o`. A load of N yields N steps.
- R7: Mode low bits 1 (count compare): the word counter steps up from 0, and the step that brings it to the stored word count sets `done_o`. A load of N yields N steps, and the counter then reads N.
- R8: Mode low bits 2 (address compare): the step taken while the address equals the stored word count sets `done_o`. That address is included, so end address E and start A give |E-A|+1 steps.
- R9: Mode low bits 3 (carry out): the word counter steps up, and the step out of all-ones sets `done_o`. A load of V yields 65536-V steps, and the counter then reads 0.
- R10: `done_o` stays at 1 and both counters hold, whatever `count_en_i` does, until opcode 4, 5 or 6 clears it.
- R11: Opcode 4 restores the address counter from its start register and restores the word counter to its mode-dependent start value (R3). It also clears `done_o`, so a re-armed transfer repeats the same step count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Opcode strobe |
| op_i | input | 3 | Opcode |
| data_i | input | 16 | Write data for mode and loads |
| data_o | output | 16 | Registered read data |
| count_en_i | input | 1 | Transfer engine requests one step |
| addr_o | output | 16 | Current address |
| done_o | output | 1 | Sticky end-of-transfer flag |

## Verification
The carry-out mode is the hardest condition to reach from the ports, because it ends only after the word counter runs through its whole top range. The bench reaches it in a few cycles by loading 65536-N. It reaches address-compare termination in both directions by placing the end address N-1 away from a random start, including wrap across zero. Every transfer drives `count_en_i` with random gaps, so the step count shows that idle cycles are skipped. After `done_o` rises, the bench holds `count_en_i` high and reinitialises, which checks that the flag is sticky and that the transfer replays.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

  typedef enum logic [2:0] {
    OP_WR_MODE = 3'd0,
    OP_RD_MODE = 3'd1,
    OP_RD_WC   = 3'd2,
    OP_RD_AC   = 3'd3,
    OP_REINIT  = 3'd4,
    OP_LD_AC   = 3'd5,
    OP_LD_WC   = 3'd6,
    OP_ARM     = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    TERM_ONE   = 2'd0,
    TERM_WCMP  = 2'd1,
    TERM_ACMP  = 2'd2,
    TERM_CARRY = 2'd3
  } term_e;

  typedef struct packed {
    logic  dn;
    term_e term;
  } mode_t;

  typedef enum logic [1:0] {
    RSRC_MODE = 2'd0,
    RSRC_WC   = 2'd1,
    RSRC_AC   = 2'd2
  } rsrc_e;

  localparam int unsigned MODE_W = $bits(mode_t);

endpackage

// File: rtl/dmag_decode.sv
module dmag_decode
  import dmag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [2:0]        op_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  output mode_t             mode_o,
  output logic              armed_o,
  output logic              ld_ac_o,
  output logic              ld_wc_o,
  output logic              reinit_o,
  output logic              rd_en_o,
  output rsrc_e             rd_src_o
);

  op_e   op;
  mode_t mode_q;
  logic  armed_q;
  logic  wr_mode;
  logic  arm;

  assign op = op_e'(op_i);

  always_comb begin
    wr_mode  = 1'b0;
    arm      = 1'b0;
    ld_ac_o  = 1'b0;
    ld_wc_o  = 1'b0;
    reinit_o = 1'b0;
    rd_en_o  = 1'b0;
    rd_src_o = RSRC_MODE;
    if (op_valid_i) begin
      unique case (op)
        OP_WR_MODE: wr_mode  = 1'b1;
        OP_RD_MODE: begin rd_en_o = 1'b1; rd_src_o = RSRC_MODE; end
        OP_RD_WC:   begin rd_en_o = 1'b1; rd_src_o = RSRC_WC;   end
        OP_RD_AC:   begin rd_en_o = 1'b1; rd_src_o = RSRC_AC;   end
        OP_REINIT:  reinit_o = 1'b1;
        OP_LD_AC:   ld_ac_o  = 1'b1;
        OP_LD_WC:   ld_wc_o  = 1'b1;
        OP_ARM:     arm      = 1'b1;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else if (wr_mode) mode_q <= mode_t'(mode_wdata_i);
  end

  // any setup opcode stops the engine until re-armed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (wr_mode || ld_ac_o || ld_wc_o || reinit_o) armed_q <= 1'b0;
    else if (arm) armed_q <= 1'b1;
  end

  assign mode_o  = mode_q;
  assign armed_o = armed_q;

endmodule

// File: rtl/dmag_addr_cnt.sv
module dmag_addr_cnt #(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic          reinit_i,
  input  logic          step_i,
  input  logic          dn_i,
  input  logic [AW-1:0] ld_val_i,
  output logic [AW-1:0] ac_o
);

  logic [AW-1:0] ac_q, start_q, ac_next;

  assign ac_next = dn_i ? ac_q - AW'(1) : ac_q + AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q    <= '0;
      start_q <= '0;
    end else if (ld_i) begin
      ac_q    <= ld_val_i;
      start_q <= ld_val_i;
    end else if (reinit_i) begin
      ac_q    <= start_q;
    end else if (step_i) begin
      ac_q    <= ac_next;
    end
  end

  assign ac_o = ac_q;

endmodule

// File: rtl/dmag_word_cnt.sv
module dmag_word_cnt #(
  parameter int unsigned WW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic          reinit_i,
  input  logic          step_i,
  input  logic          up_i,
  input  logic          zero_start_i,
  input  logic [WW-1:0] ld_val_i,
  output logic [WW-1:0] wc_o,
  output logic [WW-1:0] wc_init_o
);

  logic [WW-1:0] wc_q, init_q, wc_next;

  assign wc_next = up_i ? wc_q + WW'(1) : wc_q - WW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wc_q   <= '0;
      init_q <= '0;
    end else if (ld_i) begin
      init_q <= ld_val_i;
      wc_q   <= zero_start_i ? '0 : ld_val_i;
    end else if (reinit_i) begin
      wc_q   <= zero_start_i ? '0 : init_q;
    end else if (step_i) begin
      wc_q   <= wc_next;
    end
  end

  assign wc_o      = wc_q;
  assign wc_init_o = init_q;

endmodule

// File: rtl/dmag_term.sv
module dmag_term
  import dmag_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned WW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_req_i,
  input  logic          clr_i,
  input  term_e         term_i,
  input  logic [AW-1:0] ac_i,
  input  logic [WW-1:0] wc_i,
  input  logic [WW-1:0] wc_init_i,
  output logic          step_o,
  output logic          done_o
);

  localparam int unsigned CW = (AW > WW) ? AW : WW;

  logic          hit;
  logic          done_q;
  logic [WW-1:0] wc_inc;

  assign wc_inc = wc_i + WW'(1);

  // hit is evaluated on the pre-step value: the step taken now is the last one
  always_comb begin
    unique case (term_i)
      TERM_ONE:   hit = (wc_i == WW'(1));
      TERM_WCMP:  hit = (wc_inc == wc_init_i);
      TERM_ACMP:  hit = (CW'(ac_i) == CW'(wc_init_i));
      TERM_CARRY: hit = &wc_i;
      default:    hit = 1'b0;
    endcase
  end

  assign step_o = step_req_i && !done_q && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else if (clr_i) done_q <= 1'b0;
    else if (step_o && hit) done_q <= 1'b1;
  end

  assign done_o = done_q;

endmodule

// File: rtl/dmag_addr_gen.sv
module dmag_addr_gen
  import dmag_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 16,
  parameter int unsigned WW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [2:0]    op_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  input  logic          count_en_i,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);

  mode_t         mode;
  logic          armed;
  logic          ld_ac, ld_wc, reinit;
  logic          rd_en;
  rsrc_e         rd_src;
  logic          step;
  logic          cnt_clr;
  logic          wc_up, wc_zero_start;
  logic [AW-1:0] ac;
  logic [WW-1:0] wc, wc_init;
  logic [DW-1:0] rd_mux, rd_q;

  dmag_decode u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_valid_i   (op_valid_i),
    .op_i         (op_i),
    .mode_wdata_i (data_i[MODE_W-1:0]),
    .mode_o       (mode),
    .armed_o      (armed),
    .ld_ac_o      (ld_ac),
    .ld_wc_o      (ld_wc),
    .reinit_o     (reinit),
    .rd_en_o      (rd_en),
    .rd_src_o     (rd_src)
  );

  assign cnt_clr       = ld_ac || ld_wc || reinit;
  assign wc_up         = (mode.term != TERM_ONE);
  assign wc_zero_start = (mode.term == TERM_WCMP) || (mode.term == TERM_ACMP);

  dmag_term #(.AW(AW), .WW(WW)) u_term (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_req_i (armed && count_en_i),
    .clr_i      (cnt_clr),
    .term_i     (mode.term),
    .ac_i       (ac),
    .wc_i       (wc),
    .wc_init_i  (wc_init),
    .step_o     (step),
    .done_o     (done_o)
  );

  dmag_addr_cnt #(.AW(AW)) u_ac (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (ld_ac),
    .reinit_i (reinit),
    .step_i   (step),
    .dn_i     (mode.dn),
    .ld_val_i (data_i[AW-1:0]),
    .ac_o     (ac)
  );

  dmag_word_cnt #(.WW(WW)) u_wc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ld_i         (ld_wc),
    .reinit_i     (reinit),
    .step_i       (step),
    .up_i         (wc_up),
    .zero_start_i (wc_zero_start),
    .ld_val_i     (data_i[WW-1:0]),
    .wc_o         (wc),
    .wc_init_o    (wc_init)
  );

  always_comb begin
    unique case (rd_src)
      RSRC_MODE: rd_mux = DW'(mode);
      RSRC_WC:   rd_mux = DW'(wc);
      RSRC_AC:   rd_mux = DW'(ac);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign data_o = rd_q;
  assign addr_o = ac;

endmodule

// File: rtl/dmag_checker.sv
module dmag_checker #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          op_valid_i,
  input logic [2:0]    op_i,
  input logic [DW-1:0] data_i,
  input logic          count_en_i,
  input logic [AW-1:0] addr_o,
  input logic          done_o,
  input logic          ld_ac_i,
  input logic          ld_wc_i,
  input logic          reinit_i,
  input logic          step_i,
  input logic [2:0]    mode_i
);

  logic clr;
  assign clr = ld_ac_i || ld_wc_i || reinit_i;

  assert_mode_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 3'd0) |=> (mode_i == $past(data_i[2:0])));

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!count_en_i && !ld_ac_i && !reinit_i) |=> $stable(addr_o));

  assert_step_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !mode_i[2] && !ld_ac_i && !reinit_i) |=> (addr_o == AW'($past(addr_o) + AW'(1))));

  assert_step_dn_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mode_i[2] && !ld_ac_i && !reinit_i) |=> (addr_o == AW'($past(addr_o) - AW'(1))));

  assert_done_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr) |=> done_o);

  assert_done_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr) |=> $stable(addr_o));

  assert_done_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !done_o);

endmodule

bind dmag_addr_gen dmag_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_i       (op_i),
  .data_i     (data_i),
  .count_en_i (count_en_i),
  .addr_o     (addr_o),
  .done_o     (done_o),
  .ld_ac_i    (ld_ac),
  .ld_wc_i    (ld_wc),
  .reinit_i   (reinit),
  .step_i     (step),
  .mode_i     (mode)
);

// File: tb/dmag_addr_gen_tb.sv
module dmag_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] data_i = '0;
  logic [15:0] data_o;
  logic        count_en_i = 1'b0;
  logic [15:0] addr_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  dmag_addr_gen u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid_i),
    .op_i       (op_i),
    .data_i     (data_i),
    .data_o     (data_o),
    .count_en_i (count_en_i),
    .addr_o     (addr_o),
    .done_o     (done_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [15:0] d);
    @(negedge clk);
    op_valid_i = 1'b1; op_i = op; data_i = d;
    @(negedge clk);
    op_valid_i = 1'b0; data_i = '0;
  endtask

  task automatic rd(input logic [2:0] op, output logic [15:0] v);
    do_op(op, 16'h0);
    v = data_o;
  endtask

  // steps the engine with random gaps until done, returns steps taken
  task automatic run_xfer(input int limit, output int n);
    n = 0;
    for (int c = 0; c < limit; c++) begin
      @(negedge clk);
      if (done_o) break;
      count_en_i = ($urandom % 4) != 0;
      if (count_en_i) n++;
    end
    count_en_i = 1'b0;
  endtask

  function automatic logic [15:0] wc_load(input int mode, input int dn, input int n, input logic [15:0] a0);
    case (mode)
      0, 1:    return 16'(n);
      2:       return dn ? 16'(a0 - 16'(n - 1)) : 16'(a0 + 16'(n - 1));
      default: return 16'(65536 - n);
    endcase
  endfunction

  function automatic logic [15:0] wc_final(input int mode, input int n);
    return (mode == 1 || mode == 2) ? 16'(n) : 16'h0;
  endfunction

  function automatic logic [15:0] wc_start(input int mode, input logic [15:0] ld);
    return (mode == 1 || mode == 2) ? 16'h0 : ld;
  endfunction

  function automatic logic [15:0] addr_end(input int dn, input int n, input logic [15:0] a0);
    return dn ? 16'(a0 - 16'(n)) : 16'(a0 + 16'(n));
  endfunction

  task automatic trial(input int mode, input int dn, input int n, input logic [15:0] a0);
    logic [15:0] v, ld;
    int got;
    string tag;
    tag = (mode == 0) ? "R6" : (mode == 1) ? "R7" : (mode == 2) ? "R8" : "R9";
    ld = wc_load(mode, dn, n, a0);
    do_op(3'd0, 16'(dn * 4 + mode));
    do_op(3'd5, a0);
    do_op(3'd6, ld);
    rd(3'd3, v);
    check("R3 address readback", v, a0);
    rd(3'd2, v);
    check("R3 word counter start", v, wc_start(mode, ld));
    do_op(3'd7, 16'h0);
    run_xfer(200, got);
    check({tag, " step count"}, got, n);
    check({"R5 end address"}, addr_o, addr_end(dn, n, a0));
    rd(3'd2, v);
    check({tag, " final word count"}, v, wc_final(mode, n));
    // done holds and freezes the address with the engine still requesting
    @(negedge clk); count_en_i = 1'b1;
    repeat (3) @(negedge clk);
    count_en_i = 1'b0;
    check("R10 done sticky", done_o, 1'b1);
    check("R10 address frozen", addr_o, addr_end(dn, n, a0));
    do_op(3'd4, 16'h0);
    check("R11 reinit clears done", done_o, 1'b0);
    check("R11 address restored", addr_o, a0);
    rd(3'd2, v);
    check("R11 word counter restored", v, wc_start(mode, ld));
    // reinit disarms: requests are ignored until re-armed
    @(negedge clk); count_en_i = 1'b1;
    repeat (3) @(negedge clk);
    count_en_i = 1'b0;
    check("R4 disarmed after reinit", addr_o, a0);
    do_op(3'd7, 16'h0);
    run_xfer(200, got);
    check("R11 replay step count", got, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h1d0a_5eed));
    repeat (3) @(negedge clk);
    check("R1 reset address", addr_o, 16'h0);
    check("R1 reset done", done_o, 1'b0);
    check("R1 reset read data", data_o, 16'h0);
    rst_ni = 1'b1;
    rd(3'd1, v);
    check("R1 reset mode", v, 16'h0);
    // disarmed out of reset
    do_op(3'd5, 16'h1234);
    @(negedge clk); count_en_i = 1'b1;
    repeat (4) @(negedge clk);
    count_en_i = 1'b0;
    check("R4 disarmed after reset", addr_o, 16'h1234);

    // mode write keeps low bits only; read data holds between reads
    do_op(3'd0, 16'hFFFD);
    rd(3'd1, v);
    check("R2 mode upper bits ignored", v, 16'h0005);
    do_op(3'd5, 16'h0042);
    check("R2 read data held", data_o, 16'h0005);

    // mode write while armed disarms
    do_op(3'd0, 16'h0000);
    do_op(3'd6, 16'd10);
    do_op(3'd7, 16'h0);
    @(negedge clk); count_en_i = 1'b1;
    @(negedge clk); @(negedge clk); count_en_i = 1'b0;
    check("R4 armed steps", addr_o, 16'h0044);
    do_op(3'd0, 16'h0000);
    @(negedge clk); count_en_i = 1'b1;
    repeat (3) @(negedge clk);
    count_en_i = 1'b0;
    check("R4 disarmed by mode write", addr_o, 16'h0044);

    // directed corners: wrap across zero, single-step transfers
    trial(2, 1, 5, 16'h0002);
    trial(2, 0, 4, 16'hFFFE);
    trial(3, 0, 1, 16'h8000);
    trial(0, 1, 1, 16'h0000);
    trial(1, 0, 1, 16'hFFFF);
    trial(2, 0, 1, 16'h0100);

    for (int t = 0; t < 32; t++) begin
      trial(int'($urandom % 4), int'($urandom % 2), 1 + int'($urandom % 20), 16'($urandom));
    end
    finish_run();
  end

endmodule